// File: doc/BRIEF.md
# Memory Scrub Controller

This block sweeps a programmable window of memory in the background and repairs single-bit soft errors before a second upset can turn them into uncorrectable ones. Each visit, paced by an interval timer, reads one word through a request/grant port. The error-correction datapath sits outside the block and returns the corrected word together with two status flags: correctable and uncorrectable. A clean word causes no further traffic. A correctable word is written back in corrected form, and the same location is then read again. The result of that second read tells whether the fault was a transient upset (soft) or a stuck cell (hard).

Every finding is published as a single-cycle report that carries the address, the error kind and the error class. The system controller can log it there. Normal memory traffic always wins: a scrub access stays posted, unchanged, until the arbiter grants it. The walk runs from the start address to the end address and then wraps back to the start.

Top module: `mem_scrub_ctrl`

## Requirements
- R1: While reset is low, and afterwards until enable is raised, mem_req and rpt_valid stay low.
- R2: Scrub reads visit addresses in ascending order from start_addr to end_addr, and the address after end_addr is start_addr.
- R3: When every grant is immediate, the granted reads of two consecutive clean locations are exactly interval+4 cycles apart, and no access is requested while the timer runs.
- R4: A read that returns neither flag is followed by no write and no report.
- R5: A read with the correctable flag and without the uncorrectable flag is followed by a write to the same address of the corrected data that was returned. That write is followed by a re-read of the same address.
- R6: If the re-read returns no flag, one report is made with the address, kind 0 (correctable) and class 0 (soft).
- R7: If the re-read returns either flag, the report carries kind 0 and class 1 (hard).
- R8: A read with the uncorrectable flag is reported with kind 1 and class 1. No write or re-read follows, and the next access goes to the next address.
- R9: A request that is not granted stays asserted, with address, direction and write data unchanged, until the grant arrives.
- R10: rpt_valid is a single-cycle pulse.
- R11: Once enable is low, the controller finishes any sequence already under way and then issues no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows scrubbing |
| interval | input | TMR_W | Pacing interval in cycles between visits |
| start_addr | input | ADDR_W | First address of the window |
| end_addr | input | ADDR_W | Last address of the window |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Corrected data for write-back |
| mem_gnt | input | 1 | Grant; a read response is valid in the grant cycle |
| mem_rdata | input | DATA_W | Corrected read data from the ECC path |
| mem_ce | input | 1 | Correctable error flag for the read |
| mem_ue | input | 1 | Uncorrectable error flag for the read |
| rpt_valid | output | 1 | Error report strobe |
| rpt_addr | output | ADDR_W | Address of the reported error |
| rpt_kind | output | 1 | 0 correctable, 1 uncorrectable |
| rpt_class | output | 1 | 0 soft, 1 hard |

## Verification
The assertions check the parts that hold on every cycle. A stalled request must keep its address, direction and data. A write may only follow a correctable and not uncorrectable capture. Reports must be single pulses. An uncorrectable report must come straight from the check step. The walker must step by one and wrap exactly at the end address, and the timer must load the programmed interval. The directed scenarios show what only whole sequences can reveal. These are the order of reads, write-back and re-read on the port, and the soft-versus-hard decision for injected transient and persistent faults. They also cover the absence of traffic on clean and uncorrectable words, the exact pacing gap, and behaviour under a long arbitration stall and after disable.

// File: rtl/scrub_pkg.sv
// Shared types for the memory scrub controller.
// Assumes: one outstanding access at a time; no other state is shared.
package scrub_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_TIMER,
        ST_READ,
        ST_CHECK,
        ST_WRITEBACK,
        ST_REREAD,
        ST_CLASSIFY,
        ST_REPORT,
        ST_NEXT
    } scrub_state_t;

    localparam logic KIND_CORR   = 1'b0;
    localparam logic KIND_UNCORR = 1'b1;
    localparam logic CLASS_SOFT  = 1'b0;
    localparam logic CLASS_HARD  = 1'b1;

endpackage

// File: rtl/scrub_interval_timer.sv
// Down-counter that paces scrub visits.
// Loaded with the interval on `load`; counts down while `run` is high;
// `done` is raised in a running cycle once the count has reached zero.
// Assumes: load and run are never high together.
module scrub_interval_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [TMR_W-1:0] interval,
    output logic             done
);
    localparam logic [TMR_W-1:0] CNT_ZERO = '0;

    logic [TMR_W-1:0] cnt_q;

    // Count register: load, then decrement down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_ZERO;
        else if (load)
            cnt_q <= interval;
        else if (run && cnt_q != CNT_ZERO)
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag.
    always_comb done = run && (cnt_q == CNT_ZERO);

    // R3: a load takes the programmed interval.
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(interval));

    // R3: while running, the count never increases.
    p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/scrub_addr_walker.sv
// Holds the current scrub address.
// `init` sets it to the window start; `step` moves it one location forward
// and wraps from the window end back to the window start.
// Assumes: start_addr <= end_addr; init and step are never high together.
module scrub_addr_walker #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic at_end;

    // End-of-window detect.
    always_comb at_end = (cur_addr == end_addr);

    // Address register: initialise, increment, wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (init)
            cur_addr <= start_addr;
        else if (step)
            cur_addr <= at_end ? start_addr : cur_addr + ADDR_ONE;
    end

    // R2: stepping at the window end returns to the start.
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step && !init && at_end |=> cur_addr == $past(start_addr));

    // R2: stepping inside the window moves up by exactly one.
    p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step && !init && !at_end |=> cur_addr == $past(cur_addr) + ADDR_ONE);

    // R2: without init or step the address holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init && !step |=> $stable(cur_addr));

endmodule

// File: rtl/scrub_seq_fsm.sv
// Sequencer for one scrub visit: read, check, optional write-back and
// re-read, classification, report, then advance.
// Assumes: read data and flags are valid in the cycle the read is granted;
// a write completes in its grant cycle.
module scrub_seq_fsm
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              timer_done,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              timer_load,
    output logic              timer_run,
    output logic              walk_init,
    output logic              walk_step,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ce,
    input  logic              mem_ue,
    output logic              rpt_valid,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic              rpt_kind,
    output logic              rpt_class
);
    scrub_state_t state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic ce_q, ue_q, hard_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (enable) state_d = ST_WAIT_TIMER;
            ST_WAIT_TIMER: if (!enable) state_d = ST_IDLE;
                           else if (timer_done) state_d = ST_READ;
            ST_READ:       if (mem_gnt) state_d = ST_CHECK;
            ST_CHECK:      if (ue_q) state_d = ST_REPORT;
                           else if (ce_q) state_d = ST_WRITEBACK;
                           else state_d = ST_NEXT;
            ST_WRITEBACK:  if (mem_gnt) state_d = ST_REREAD;
            ST_REREAD:     if (mem_gnt) state_d = ST_CLASSIFY;
            ST_CLASSIFY:   state_d = ST_REPORT;
            ST_REPORT:     state_d = ST_NEXT;
            ST_NEXT:       state_d = enable ? ST_WAIT_TIMER : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture of the first read: corrected data and both flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ce_q   <= 1'b0;
            ue_q   <= 1'b0;
        end else if (state_q == ST_READ && mem_gnt) begin
            data_q <= mem_rdata;
            ce_q   <= mem_ce;
            ue_q   <= mem_ue;
        end
    end

    // Capture of the re-read verdict: any flag means a hard fault.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hard_q <= 1'b0;
        else if (state_q == ST_REREAD && mem_gnt)
            hard_q <= mem_ce || mem_ue;
    end

    // Control strobes for the timer and the walker.
    always_comb begin
        timer_load = (state_q == ST_IDLE && enable) || (state_q == ST_NEXT);
        timer_run  = (state_q == ST_WAIT_TIMER);
        walk_init  = (state_q == ST_IDLE);
        walk_step  = (state_q == ST_NEXT);
    end

    // Memory port drive.
    always_comb begin
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITEBACK) ||
                    (state_q == ST_REREAD);
        mem_we    = (state_q == ST_WRITEBACK);
        mem_addr  = cur_addr;
        mem_wdata = data_q;
    end

    // Error report drive.
    always_comb begin
        rpt_valid = (state_q == ST_REPORT);
        rpt_addr  = cur_addr;
        rpt_kind  = ue_q ? KIND_UNCORR : KIND_CORR;
        rpt_class = (ue_q || hard_q) ? CLASS_HARD : CLASS_SOFT;
    end

    // R9: an ungranted request is held unchanged.
    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));

    // R5: a write is issued only for a correctable, not uncorrectable, read.
    p_wb_corr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> ce_q && !ue_q);

    // R10: the report strobe lasts one cycle.
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> !rpt_valid);

    // R8: an uncorrectable report follows the check step directly.
    p_ue_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && rpt_kind |-> $past(state_q) == ST_CHECK);

    // R11: disabled and idle means no request next cycle.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && state_q == ST_IDLE |=> !mem_req);

endmodule

// File: rtl/mem_scrub_ctrl.sv
// Top of the background memory scrub controller.
// Connects the pacing timer, the address walker and the visit sequencer.
// Assumes: start_addr <= end_addr and both are held steady while enabled.
module mem_scrub_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [TMR_W-1:0]  interval,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ce,
    input  logic              mem_ue,
    output logic              rpt_valid,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic              rpt_kind,
    output logic              rpt_class
);
    logic timer_load, timer_run, timer_done;
    logic walk_init, walk_step;
    logic [ADDR_W-1:0] cur_addr;

    scrub_interval_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .run      (timer_run),
        .interval (interval),
        .done     (timer_done)
    );

    scrub_addr_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (walk_init),
        .step       (walk_step),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .cur_addr   (cur_addr)
    );

    scrub_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .timer_done (timer_done),
        .cur_addr   (cur_addr),
        .timer_load (timer_load),
        .timer_run  (timer_run),
        .walk_init  (walk_init),
        .walk_step  (walk_step),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .mem_ce     (mem_ce),
        .mem_ue     (mem_ue),
        .rpt_valid  (rpt_valid),
        .rpt_addr   (rpt_addr),
        .rpt_kind   (rpt_kind),
        .rpt_class  (rpt_class)
    );

    // R1: no request and no report while held in reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !rpt_valid);

endmodule

// File: tb/tb_mem_scrub_ctrl.sv
// Directed bench for mem_scrub_ctrl with a small memory and fault injection.
module tb_mem_scrub_ctrl;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int TMR_W  = 16;
    localparam int LOGN   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [TMR_W-1:0]  interval = '0;
    logic [ADDR_W-1:0] start_addr = '0, end_addr = '0;
    logic mem_req, mem_we, mem_gnt, mem_ce, mem_ue;
    logic [ADDR_W-1:0] mem_addr, rpt_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic rpt_valid, rpt_kind, rpt_class;

    always #5 clk = ~clk;

    mem_scrub_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .interval(interval),
        .start_addr(start_addr), .end_addr(end_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_ce(mem_ce), .mem_ue(mem_ue), .rpt_valid(rpt_valid),
        .rpt_addr(rpt_addr), .rpt_kind(rpt_kind), .rpt_class(rpt_class)
    );

    // Memory model: fault flags per location, fixed corrected contents.
    logic [15:0] soft_f = '0, hard_f = '0, ue_f = '0;
    logic busy = 1'b0;

    function automatic logic [DATA_W-1:0] golden(input logic [ADDR_W-1:0] a);
        return 32'h5A5A_0000 | (32'(a) * 32'h0101);
    endfunction

    assign mem_gnt   = mem_req && !busy;
    assign mem_rdata = golden(mem_addr);
    assign mem_ce    = mem_req && !mem_we && (soft_f[mem_addr[3:0]] || hard_f[mem_addr[3:0]]);
    assign mem_ue    = mem_req && !mem_we && ue_f[mem_addr[3:0]];

    // Access and report logs.
    int checks = 0, errors = 0, cyc = 0;
    int acc_n = 0, rpt_n = 0, wr_n = 0, wbad = 0, dbl_pulse = 0;
    logic acc_we [LOGN];
    int   acc_adr [LOGN];
    int   acc_cyc [LOGN];
    int   r_adr [16];
    logic r_kind [16];
    logic r_cls [16];
    logic prev_rpt = 1'b0;
    bit   done = 0;

    // Monitor away from the active edge: log granted accesses and reports.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && mem_req && mem_gnt) begin
            if (acc_n < LOGN) begin
                acc_we[acc_n]  = mem_we;
                acc_adr[acc_n] = int'(mem_addr);
                acc_cyc[acc_n] = cyc;
            end
            acc_n++;
            if (mem_we) begin
                wr_n++;
                if (mem_wdata != golden(mem_addr)) wbad++;
                soft_f[mem_addr[3:0]] = 1'b0;
            end
        end
        if (rst_n && rpt_valid) begin
            if (rpt_n < 16) begin
                r_adr[rpt_n]  = int'(rpt_addr);
                r_kind[rpt_n] = rpt_kind;
                r_cls[rpt_n]  = rpt_class;
            end
            rpt_n++;
            if (prev_rpt) dbl_pulse++;
        end
        prev_rpt = rpt_valid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        acc_n = 0; rpt_n = 0; wr_n = 0; wbad = 0;
    endtask

    task automatic chk_acc(input int i, input logic we, input int adr, input string req);
        chk(acc_n > i, req, $sformatf("access %0d present", i), acc_n, i + 1);
        if (acc_n > i) begin
            chk(acc_we[i] == we, req, $sformatf("access %0d direction", i), int'(acc_we[i]), int'(we));
            chk(acc_adr[i] == adr, req, $sformatf("access %0d address", i), acc_adr[i], adr);
        end
    endtask

    // Set the window, enable for a while, then disable and let it settle.
    task automatic run_cfg(input int s, input int e, input int iv, input int ncyc);
        enable = 1'b0;
        repeat (40) @(negedge clk);
        start_addr = ADDR_W'(s);
        end_addr   = ADDR_W'(e);
        interval   = TMR_W'(iv);
        clear_logs();
        enable = 1'b1;
        repeat (ncyc) @(negedge clk);
        enable = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0, "R1", "req in reset", int'(mem_req), 0);
        chk(rpt_valid == 1'b0, "R1", "report in reset", int'(rpt_valid), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(acc_n == 0 && mem_req == 1'b0, "R1", "accesses before enable", acc_n, 0);
    endtask

    task automatic t_clean_sweep();
        run_cfg(2, 5, 3, 70);
        chk_acc(0, 1'b0, 2, "R2");
        chk_acc(1, 1'b0, 3, "R2");
        chk_acc(2, 1'b0, 4, "R2");
        chk_acc(3, 1'b0, 5, "R2");
        chk_acc(4, 1'b0, 2, "R2");
        chk(acc_cyc[1] - acc_cyc[0] == 7, "R3", "pacing gap", acc_cyc[1] - acc_cyc[0], 7);
        chk(acc_cyc[2] - acc_cyc[1] == 7, "R3", "pacing gap 2", acc_cyc[2] - acc_cyc[1], 7);
        chk(wr_n == 0, "R4", "writes on clean data", wr_n, 0);
        chk(rpt_n == 0, "R4", "reports on clean data", rpt_n, 0);
    endtask

    task automatic t_soft();
        soft_f[3] = 1'b1;
        run_cfg(3, 4, 2, 60);
        chk_acc(0, 1'b0, 3, "R5");
        chk_acc(1, 1'b1, 3, "R5");
        chk_acc(2, 1'b0, 3, "R5");
        chk_acc(3, 1'b0, 4, "R5");
        chk_acc(4, 1'b0, 3, "R5");
        chk(wbad == 0, "R5", "write-back data mismatches", wbad, 0);
        chk(rpt_n == 1, "R6", "soft report count", rpt_n, 1);
        chk(r_adr[0] == 3, "R6", "soft report address", r_adr[0], 3);
        chk(r_kind[0] == 1'b0, "R6", "soft report kind", int'(r_kind[0]), 0);
        chk(r_cls[0] == 1'b0, "R6", "soft report class", int'(r_cls[0]), 0);
    endtask

    task automatic t_hard();
        hard_f[6] = 1'b1;
        run_cfg(6, 6, 2, 40);
        chk_acc(0, 1'b0, 6, "R7");
        chk_acc(1, 1'b1, 6, "R7");
        chk_acc(2, 1'b0, 6, "R7");
        chk_acc(3, 1'b0, 6, "R2");
        chk(rpt_n >= 1, "R7", "hard report present", rpt_n, 1);
        chk(r_adr[0] == 6, "R7", "hard report address", r_adr[0], 6);
        chk(r_kind[0] == 1'b0, "R7", "hard report kind", int'(r_kind[0]), 0);
        chk(r_cls[0] == 1'b1, "R7", "hard report class", int'(r_cls[0]), 1);
        hard_f[6] = 1'b0;
    endtask

    task automatic t_uncorr();
        ue_f[9] = 1'b1;
        run_cfg(8, 10, 2, 50);
        chk_acc(0, 1'b0, 8, "R8");
        chk_acc(1, 1'b0, 9, "R8");
        chk_acc(2, 1'b0, 10, "R8");
        chk_acc(3, 1'b0, 8, "R8");
        chk(wr_n == 0, "R8", "writes after uncorrectable", wr_n, 0);
        chk(rpt_n >= 1, "R8", "uncorrectable report present", rpt_n, 1);
        chk(r_adr[0] == 9, "R8", "report address", r_adr[0], 9);
        chk(r_kind[0] == 1'b1, "R8", "report kind", int'(r_kind[0]), 1);
        chk(r_cls[0] == 1'b1, "R8", "report class", int'(r_cls[0]), 1);
        ue_f[9] = 1'b0;
    endtask

    task automatic t_stall();
        enable = 1'b0;
        repeat (40) @(negedge clk);
        start_addr = 8'd0;
        end_addr   = 8'd1;
        interval   = 16'd2;
        clear_logs();
        busy   = 1'b1;
        enable = 1'b1;
        repeat (30) @(negedge clk);
        chk(acc_n == 0, "R9", "accesses while busy", acc_n, 0);
        chk(mem_req == 1'b1, "R9", "request held", int'(mem_req), 1);
        chk(mem_addr == 8'd0 && mem_we == 1'b0, "R9", "held address", int'(mem_addr), 0);
        busy = 1'b0;
        repeat (40) @(negedge clk);
        enable = 1'b0;
        repeat (40) @(negedge clk);
        chk_acc(0, 1'b0, 0, "R9");
        chk_acc(1, 1'b0, 1, "R9");
        chk_acc(2, 1'b0, 0, "R9");
    endtask

    task automatic t_disable();
        clear_logs();
        repeat (60) @(negedge clk);
        chk(acc_n == 0, "R11", "accesses after disable", acc_n, 0);
        chk(mem_req == 1'b0, "R11", "request after disable", int'(mem_req), 0);
        chk(dbl_pulse == 0, "R10", "multi-cycle report pulses", dbl_pulse, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_clean_sweep();
        t_soft();
        t_hard();
        t_uncorr();
        t_stall();
        t_disable();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule